// File: doc/BRIEF.md
# Partitioned Concurrent Error Detector for a Coded State Machine

This block is a small finite-state machine whose state and outputs are kept in constant-weight codes, together with the checking logic that watches those codes in every cycle. The state register holds a 3-out-of-6 code. The output vector is split into four fixed groups, and each group has its own small checker. Two groups are one-hot, one is 3-out-of-5, and one is a Berger-coded field. A fifth checker watches the state code. There is no single wide checker across all outputs.

Each checker reports a two-rail pair. A cascade of two-rail combining cells merges the five pairs into one. The merged pair is valid only while every checker sees a code word. A sticky error flag captures any invalid merged pair on the next clock edge and keeps it until a synchronous clear.

For verification, fault-injection masks are applied where the state register and the output groups are read. A set mask forces chosen bits to 1 and a clear mask forces chosen bits to 0. This lets a test impose unidirectional errors of any multiplicity without changing the stored state.

Top module: `scfsm_err_detect`

## Requirements
- R1: While reset is low and just after it is released, `state_code` equals 6'b000111, `err_flag` is 0 and `chk_pair` is 01 or 10.
- R2: With no state fault applied, `state_code` is the k-th 6-bit value of weight 3 in ascending order (7, 11, 13, 14, 19, 21, 22, 25 for k = 0..7). A clock edge with `adv` = 1 moves k to (k + 1 + `sel`) mod 8. A clock edge with `adv` = 0 leaves k unchanged.
- R3: `out_word[9:0]` is one-hot, with its 1 at bit (k + `din`) mod 10.
- R4: `out_word[13:10]` is one-hot, with its 1 at bit 10 + (`din` mod 4).
- R5: `out_word[18:14]` is the j-th 5-bit value of weight 3 in ascending order (7, 11, 13, 14, 19, 21, 22, 25, 26, 28), where j = (k + `din[3:2]`) mod 10.
- R6: `out_word[22:19]` equals `din`, and `out_word[25:23]` holds the number of zero bits in `din`, written in binary.
- R7: With no fault mask applied, `chk_pair` is 01 or 10 in every cycle, and `err_flag` stays 0.
- R8: A unidirectional error of one or more bits inside any single output group, whether set-only or clear-only, makes `chk_pair` 00 or 11 in the same cycle.
- R9: `err_flag` becomes 1 on the clock edge at which `chk_pair` is 00 or 11. It then stays 1 until an edge with `flag_clr` = 1 clears it. A clear takes priority over a new error on the same edge.
- R10: A unidirectional error of one or more bits in the state code makes `chk_pair` 00 or 11 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Take a state transition at this edge |
| sel | input | 2 | Transition stride minus one |
| din | input | 4 | Data input that shapes the coded outputs |
| st_set | input | 6 | Forces state-code bits to 1 where set |
| st_clr | input | 6 | Forces state-code bits to 0 where set |
| out_set | input | 26 | Forces output bits to 1 where set |
| out_clr | input | 26 | Forces output bits to 0 where set |
| flag_clr | input | 1 | Synchronous clear of the error flag |
| state_code | output | 6 | State code as seen after fault masks |
| out_word | output | 26 | Coded output vector after fault masks |
| chk_pair | output | 2 | Merged two-rail result |
| err_flag | output | 1 | Sticky registered error flag |

## Verification
Fault-free walks vary `sel`, `adv` and `din` so that every group code moves through several code words. These walks show that the checkers accept each legal code word and never raise the flag. Set-only and clear-only masks of one and two bits are placed inside each output group in turn, under three `din` values. The all-zero data value gives the Berger group a field with a large check value. This separates the one-hot, 3-of-5 and Berger checks, and a fault confined to one group must still reach the merged pair. State masks of one, two and three bits test the state checker. Further sequences place `flag_clr` alongside a live fault to check that the flag is sticky and that a clear wins over a new error.

// File: rtl/scfsm_pkg.sv
// Shared types and constant helpers for the coded state machine checker.
// Assumes code widths below 31 bits, so that int arithmetic covers them.
package scfsm_pkg;

    // Two-rail pair {t, f}: 01 or 10 means code-valid, 00 or 11 means error.
    typedef logic [1:0] rail_t;

    // Number of n-bit values that have exactly m ones.
    function automatic int num_mofn(int n, int m);
        int cnt;
        cnt = 0;
        for (int v = 0; v < (1 << n); v++)
            if ($countones(v) == m) cnt++;
        return cnt;
    endfunction

    // The k-th n-bit value of weight m, in ascending order.
    function automatic int nth_mofn(int n, int m, int k);
        int seen;
        int res;
        seen = 0;
        res  = 0;
        for (int v = 0; v < (1 << n); v++) begin
            if ($countones(v) == m) begin
                if (seen == k) res = v;
                seen++;
            end
        end
        return res;
    endfunction

    // Two-rail combining cell: the output is valid only when both inputs are valid.
    function automatic rail_t rail_join(rail_t a, rail_t b);
        return {(a[1] & b[1]) | (a[0] & b[0]), (a[1] & b[0]) | (a[0] & b[1])};
    endfunction

endpackage

// File: rtl/scfsm_mofn_chk.sv
// Constant-weight checker: the word is a code word when exactly M of its N bits are 1.
// The valid pair follows the word parity, so both rails toggle in normal operation.
module scfsm_mofn_chk
    import scfsm_pkg::*;
#(
    parameter int N = 5,
    parameter int M = 3,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0] word,
    output rail_t        pair
);
    logic [CW-1:0] ones;
    logic          ok;
    logic          par;

    // Count the ones and form the two-rail pair.
    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++)
            if (word[i]) ones = ones + CW'(1);
        ok   = (ones == CW'(M));
        par  = ^word;
        pair = {par, ok ? ~par : par};
    end
endmodule

// File: rtl/scfsm_berger_chk.sv
// Berger checker: the upper C bits must equal the binary count of zeros in the lower D bits.
// This catches any unidirectional error that spans the data and check fields.
module scfsm_berger_chk
    import scfsm_pkg::*;
#(
    parameter int D = 4,
    localparam int C = $clog2(D + 1)
) (
    input  logic [D+C-1:0] word,
    output rail_t          pair
);
    logic [C-1:0] zc;
    logic         ok;
    logic         par;

    // Count the zeros in the data field and compare with the check field.
    always_comb begin
        zc = '0;
        for (int i = 0; i < D; i++)
            if (!word[i]) zc = zc + C'(1);
        ok   = (word[D+C-1:D] == zc);
        par  = ^word;
        pair = {par, ok ? ~par : par};
    end
endmodule

// File: rtl/scfsm_rail_merge.sv
// Two-rail merge: folds P checker pairs into one through a cascade of combining cells.
// An invalid pair at any input yields an invalid output pair.
module scfsm_rail_merge
    import scfsm_pkg::*;
#(
    parameter int P = 5
) (
    input  rail_t pairs [P],
    output rail_t merged
);
    // Fold each pair into the accumulated result in turn.
    always_comb begin
        merged = pairs[0];
        for (int i = 1; i < P; i++)
            merged = rail_join(merged, pairs[i]);
    end
endmodule

// File: rtl/scfsm_fsm.sv
// Demonstration machine: the state is held as an m-of-n code, and the outputs are
// produced as one-hot, m-of-n and Berger-coded groups. Fault masks act on the read side
// of the register and on the outputs. Assumes NST does not exceed the number of state codes.
module scfsm_fsm
    import scfsm_pkg::*;
#(
    parameter int ST_N  = 6,
    parameter int ST_M  = 3,
    parameter int NST   = 8,
    parameter int SEL_W = 2,
    parameter int DIN_W = 4,
    parameter int G0_N  = 10,
    parameter int G1_N  = 4,
    parameter int G2_N  = 5,
    parameter int G2_M  = 3,
    localparam int BG_C  = $clog2(DIN_W + 1),
    localparam int OUT_W = G0_N + G1_N + G2_N + DIN_W + BG_C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIN_W-1:0] din,
    input  logic [ST_N-1:0]  st_set,
    input  logic [ST_N-1:0]  st_clr,
    input  logic [OUT_W-1:0] out_set,
    input  logic [OUT_W-1:0] out_clr,
    output logic [ST_N-1:0]  state_code,
    output logic [OUT_W-1:0] out_word
);
    localparam int IDX_W  = (NST > 1) ? $clog2(NST) : 1;
    localparam int G2_CNT = num_mofn(G2_N, G2_M);
    localparam int G2_IW  = (G2_CNT > 1) ? $clog2(G2_CNT) : 1;
    localparam logic [ST_N-1:0] RST_CODE = ST_N'(nth_mofn(ST_N, ST_M, 0));

    logic [ST_N-1:0]  state_q;
    logic [ST_N-1:0]  st_view;
    logic [ST_N-1:0]  st_tab [NST];
    logic [G2_N-1:0]  g2_tab [G2_CNT];
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] nxt_idx;
    logic [G0_N-1:0]  g0;
    logic [G1_N-1:0]  g1;
    logic [G2_N-1:0]  g2;
    logic [BG_C-1:0]  zc;

    // State code table in ascending order of value.
    for (genvar si = 0; si < NST; si++) begin : g_st_tab
        assign st_tab[si] = ST_N'(nth_mofn(ST_N, ST_M, si));
    end

    // Code table for the m-of-n output group.
    for (genvar gi = 0; gi < G2_CNT; gi++) begin : g_g2_tab
        assign g2_tab[gi] = G2_N'(nth_mofn(G2_N, G2_M, gi));
    end

    // The register as seen after the unidirectional fault masks.
    assign st_view    = (state_q | st_set) & ~st_clr;
    assign state_code = st_view;

    // Turn the observed state code back into a state index.
    always_comb begin
        cur_idx = '0;
        for (int i = 0; i < NST; i++)
            if (st_view == st_tab[i]) cur_idx = IDX_W'(i);
    end

    // Next state index: advance by a stride of one plus sel.
    always_comb begin
        int t;
        t       = (int'(cur_idx) + 1 + int'(sel)) % NST;
        nxt_idx = IDX_W'(t);
    end

    // Coded state register.
    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= RST_CODE;
        else if (adv) state_q <= st_tab[nxt_idx];
    end

    // Output groups: two one-hot, one m-of-n and one Berger field.
    always_comb begin
        int p0;
        int p1;
        int p2;
        p0 = (int'(cur_idx) + int'(din)) % G0_N;
        p1 = int'(din) % G1_N;
        p2 = (int'(cur_idx) + int'(din >> 2)) % G2_CNT;
        g0 = G0_N'(1) << p0;
        g1 = G1_N'(1) << p1;
        g2 = g2_tab[G2_IW'(p2)];
        zc = '0;
        for (int i = 0; i < DIN_W; i++)
            if (!din[i]) zc = zc + BG_C'(1);
    end

    // Apply the output fault masks.
    assign out_word = ({zc, din, g2, g1, g0} | out_set) & ~out_clr;
endmodule

// File: rtl/scfsm_err_detect.sv
// Top: coded machine, one checker for each output group plus a state checker, a
// two-rail merge and a sticky error flag. Synchronous active-low reset.
module scfsm_err_detect
    import scfsm_pkg::*;
#(
    parameter int ST_N  = 6,
    parameter int ST_M  = 3,
    parameter int NST   = 8,
    parameter int SEL_W = 2,
    parameter int DIN_W = 4,
    parameter int G0_N  = 10,
    parameter int G1_N  = 4,
    parameter int G2_N  = 5,
    parameter int G2_M  = 3,
    localparam int BG_C  = $clog2(DIN_W + 1),
    localparam int OUT_W = G0_N + G1_N + G2_N + DIN_W + BG_C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIN_W-1:0] din,
    input  logic [ST_N-1:0]  st_set,
    input  logic [ST_N-1:0]  st_clr,
    input  logic [OUT_W-1:0] out_set,
    input  logic [OUT_W-1:0] out_clr,
    input  logic             flag_clr,
    output logic [ST_N-1:0]  state_code,
    output logic [OUT_W-1:0] out_word,
    output logic [1:0]       chk_pair,
    output logic             err_flag
);
    localparam int O1   = G0_N;
    localparam int O2   = O1 + G1_N;
    localparam int O3   = O2 + G2_N;
    localparam int NCHK = 5;

    rail_t pairs [NCHK];
    rail_t merged;

    scfsm_fsm #(
        .ST_N(ST_N), .ST_M(ST_M), .NST(NST), .SEL_W(SEL_W), .DIN_W(DIN_W),
        .G0_N(G0_N), .G1_N(G1_N), .G2_N(G2_N), .G2_M(G2_M)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .adv(adv), .sel(sel), .din(din),
        .st_set(st_set), .st_clr(st_clr), .out_set(out_set), .out_clr(out_clr),
        .state_code(state_code), .out_word(out_word)
    );

    scfsm_mofn_chk #(.N(ST_N), .M(ST_M)) i_chk_st (.word(state_code), .pair(pairs[0]));
    scfsm_mofn_chk #(.N(G0_N), .M(1)) i_chk_g0 (.word(out_word[O1-1:0]), .pair(pairs[1]));
    scfsm_mofn_chk #(.N(G1_N), .M(1)) i_chk_g1 (.word(out_word[O2-1:O1]), .pair(pairs[2]));
    scfsm_mofn_chk #(.N(G2_N), .M(G2_M)) i_chk_g2 (.word(out_word[O3-1:O2]), .pair(pairs[3]));
    scfsm_berger_chk #(.D(DIN_W)) i_chk_g3 (.word(out_word[OUT_W-1:O3]), .pair(pairs[4]));

    scfsm_rail_merge #(.P(NCHK)) i_merge (.pairs(pairs), .merged(merged));

    assign chk_pair = merged;

    // Sticky error flag: a clear wins, otherwise latch any invalid merged pair.
    always_ff @(posedge clk) begin
        if (!rst_n)                   err_flag <= 1'b0;
        else if (flag_clr)            err_flag <= 1'b0;
        else if (merged[1] == merged[0]) err_flag <= 1'b1;
    end
endmodule

// File: rtl/scfsm_err_detect_sva.sv
// Property checker for scfsm_err_detect, attached with bind. Watches ports only.
module scfsm_err_detect_sva #(
    parameter int ST_N  = 6,
    parameter int OUT_W = 26,
    parameter int G0_N  = 10,
    parameter int G1_N  = 4,
    parameter int G2_N  = 5,
    parameter int G2_M  = 3,
    parameter int ST_M  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic [ST_N-1:0]  st_set,
    input logic [ST_N-1:0]  st_clr,
    input logic [OUT_W-1:0] out_set,
    input logic [OUT_W-1:0] out_clr,
    input logic             flag_clr,
    input logic [ST_N-1:0]  state_code,
    input logic [OUT_W-1:0] out_word,
    input logic [1:0]       chk_pair,
    input logic             err_flag
);
    logic st_nf;
    logic all_nf;
    assign st_nf  = (st_set == '0) && (st_clr == '0);
    assign all_nf = st_nf && (out_set == '0) && (out_clr == '0);

    AST_STATE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        st_nf |-> ($countones(state_code) == ST_M)); // R2
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && st_nf) |=> (!st_nf || $stable(state_code))); // R2
    AST_G0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        all_nf |-> ($countones(out_word[G0_N-1:0]) == 1)); // R3
    AST_G1_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        all_nf |-> ($countones(out_word[G0_N+G1_N-1:G0_N]) == 1)); // R4
    AST_G2_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        all_nf |-> ($countones(out_word[G0_N+G1_N+G2_N-1:G0_N+G1_N]) == G2_M)); // R5
    AST_PAIR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        all_nf |-> (chk_pair == 2'b01 || chk_pair == 2'b10)); // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((chk_pair[1] == chk_pair[0]) && !flag_clr) |=> err_flag); // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !flag_clr) |=> err_flag); // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !err_flag); // R9
endmodule

bind scfsm_err_detect scfsm_err_detect_sva #(
    .ST_N(ST_N), .OUT_W(OUT_W), .G0_N(G0_N), .G1_N(G1_N),
    .G2_N(G2_N), .G2_M(G2_M), .ST_M(ST_M)
) i_sva (
    .clk(clk), .rst_n(rst_n), .adv(adv), .st_set(st_set), .st_clr(st_clr),
    .out_set(out_set), .out_clr(out_clr), .flag_clr(flag_clr),
    .state_code(state_code), .out_word(out_word), .chk_pair(chk_pair),
    .err_flag(err_flag)
);

// File: tb/test_scfsm_err_detect.sv
// Directed bench for scfsm_err_detect: fault-free walks plus injected unidirectional faults.
module test_scfsm_err_detect;
    logic        clk = 1'b0;
    logic        rst_n, adv, flag_clr;
    logic [1:0]  sel;
    logic [3:0]  din;
    logic [5:0]  st_set, st_clr, state_code;
    logic [25:0] out_set, out_clr, out_word;
    logic [1:0]  chk_pair;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int k      = 0;

    always #10 clk = ~clk;

    scfsm_err_detect i_scfsm_err_detect (
        .clk(clk), .rst_n(rst_n), .adv(adv), .sel(sel), .din(din),
        .st_set(st_set), .st_clr(st_clr), .out_set(out_set), .out_clr(out_clr),
        .flag_clr(flag_clr), .state_code(state_code), .out_word(out_word),
        .chk_pair(chk_pair), .err_flag(err_flag)
    );

    // k-th n-bit value of weight m in ascending order, taken from the requirements.
    function automatic int kth(int n, int m, int idx);
        int found = -1;
        for (int v = 0; v < (1 << n); v++)
            if ($countones(v) == m) begin
                found++;
                if (found == idx) return v;
            end
        return 0;
    endfunction

    function automatic logic [25:0] exp_word(int kk, logic [3:0] d);
        logic [9:0] a;
        logic [3:0] b;
        logic [4:0] c;
        logic [2:0] z;
        a = 10'd1 << ((kk + int'(d)) % 10);
        b = 4'd1 << (int'(d) % 4);
        c = 5'(kth(5, 3, (kk + int'(d[3:2])) % 10));
        z = 3'(4 - $countones(d));
        return {z, d, c, b, a};
    endfunction

    // First cnt bits within [lo:hi] of w whose value equals want.
    function automatic logic [25:0] pick(logic [25:0] w, int lo, int hi, bit want, int cnt);
        logic [25:0] m = '0;
        int got = 0;
        for (int i = lo; i <= hi; i++)
            if (w[i] == want && got < cnt) begin
                m[i] = 1'b1;
                got++;
            end
        return m;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit pair_ok(logic [1:0] p);
        return (p == 2'b01) || (p == 2'b10);
    endfunction

    // R1: values during and right after reset.
    task automatic t_reset();
        rst_n = 1'b0; adv = 0; sel = 0; din = 0; flag_clr = 0;
        st_set = 0; st_clr = 0; out_set = 0; out_clr = 0;
        repeat (3) @(negedge clk);
        check(state_code == 6'b000111, "R1", "state in reset", state_code, 6'b000111);
        check(err_flag == 1'b0, "R1", "flag in reset", err_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(state_code == 6'b000111, "R1", "state after reset", state_code, 6'b000111);
        check(err_flag == 1'b0, "R1", "flag after reset", err_flag, 0);
        check(pair_ok(chk_pair), "R1", "pair after reset", chk_pair, 1);
        k = 0;
    endtask

    // One fault-free cycle with the output groups checked against the model (R2..R7).
    task automatic step(bit a, logic [1:0] s, logic [3:0] d);
        logic [25:0] e;
        @(negedge clk);
        adv = a; sel = s; din = d;
        #1;
        e = exp_word(k, d);
        check(state_code == 6'(kth(6, 3, k)), "R2", "state code", state_code, kth(6, 3, k));
        check(out_word[9:0] == e[9:0], "R3", "group0", out_word[9:0], e[9:0]);
        check(out_word[13:10] == e[13:10], "R4", "group1", out_word[13:10], e[13:10]);
        check(out_word[18:14] == e[18:14], "R5", "group2", out_word[18:14], e[18:14]);
        check(out_word[25:19] == e[25:19], "R6", "berger group", out_word[25:19], e[25:19]);
        check(pair_ok(chk_pair), "R7", "fault-free pair", chk_pair, 1);
        @(posedge clk);
        if (a) k = (k + 1 + int'(s)) % 8;
        #5;
        check(err_flag == 1'b0, "R7", "fault-free flag", err_flag, 0);
    endtask

    task automatic t_walk(int n, int seed);
        for (int i = 0; i < n; i++)
            step((i % 3) != 2, 2'((i + seed) % 4), 4'((i * 7 + seed) % 16));
    endtask

    // Apply one fault, check detection, flag capture, stickiness and clear (R8/R10, R9).
    task automatic inject(string req, logic [5:0] ss, logic [5:0] sc,
                          logic [25:0] os, logic [25:0] oc);
        @(negedge clk);
        adv = 0; st_set = ss; st_clr = sc; out_set = os; out_clr = oc;
        #1;
        check(!pair_ok(chk_pair), req, "fault detected", chk_pair, 0);
        @(negedge clk);
        check(err_flag == 1'b1, "R9", "flag set next edge", err_flag, 1);
        st_set = 0; st_clr = 0; out_set = 0; out_clr = 0;
        @(negedge clk);
        check(err_flag == 1'b1, "R9", "flag sticky", err_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        check(err_flag == 1'b0, "R9", "flag cleared", err_flag, 0);
        flag_clr = 1'b0;
    endtask

    // R8: set-only and clear-only faults of one and two bits in each output group.
    task automatic t_out_faults(logic [3:0] d);
        int lo [4] = '{0, 10, 14, 19};
        int hi [4] = '{9, 13, 18, 25};
        logic [25:0] e;
        logic [25:0] m;
        step(1'b0, 2'd0, d);
        e = exp_word(k, d);
        for (int g = 0; g < 4; g++)
            for (int w = 0; w < 2; w++)
                for (int c = 1; c <= 2; c++) begin
                    m = pick(e, lo[g], hi[g], w[0] ? 1'b1 : 1'b0, c);
                    if ($countones(m) == c) begin
                        if (w == 0) inject("R8", 6'd0, 6'd0, m, 26'd0);
                        else        inject("R8", 6'd0, 6'd0, 26'd0, m);
                    end
                end
    endtask

    // R10: unidirectional faults of one to three bits on the state code.
    task automatic t_state_faults();
        logic [25:0] code;
        code = 26'(kth(6, 3, k));
        for (int c = 1; c <= 3; c++) begin
            inject("R10", 6'(pick(code, 0, 5, 1'b0, c)), 6'd0, 26'd0, 26'd0);
            inject("R10", 6'd0, 6'(pick(code, 0, 5, 1'b1, c)), 26'd0, 26'd0);
        end
    endtask

    // R9: a clear on the same edge as a live error wins; the error then captures.
    task automatic t_clr_priority();
        @(negedge clk);
        adv = 0; out_clr = pick(exp_word(k, din), 10, 13, 1'b1, 1); flag_clr = 1'b1;
        #1;
        check(!pair_ok(chk_pair), "R8", "group1 clear fault", chk_pair, 0);
        @(negedge clk);
        check(err_flag == 1'b0, "R9", "clear beats error", err_flag, 0);
        flag_clr = 1'b0;
        @(negedge clk);
        check(err_flag == 1'b1, "R9", "error after clear", err_flag, 1);
        out_clr = 0; flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check(err_flag == 1'b0, "R9", "stays clear", err_flag, 0);
    endtask

    initial begin
        t_reset();
        t_walk(12, 3);
        t_out_faults(4'b0101);
        t_walk(5, 1);
        t_out_faults(4'b1110);
        t_out_faults(4'b0000);
        t_state_faults();
        t_walk(3, 2);
        t_state_faults();
        t_clr_priority();
        t_walk(10, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule